// File: doc/BRIEF.md
# In-Order Column DRAM Command Scheduler

This block keeps a short queue of pending memory requests. Each request names a bank, a row, a direction (read or write), an auto-precharge flag and a tag. A command slot is offered to one bank at a time. The block answers with the next DRAM command for that bank (precharge, activate, one of four column commands, or no-operation), along with the tag and row of the request it serves. It keeps an open flag and an open-row register for every bank, and picks precharge, activate or a column access from them.

Column accesses (reads and writes) leave in strict arrival order across all banks. Row preparation may run ahead: the oldest request for an offered bank may receive its precharge or activate while an older request to another bank still holds the head of the queue. A request leaves the queue only when its column command is issued. DRAM timing, refresh and the data path belong to other blocks.

Top module: `ios_sched`

## Requirements
- R1: `req_ready` is high exactly when fewer than DEPTH requests are queued. A request with `req_valid` and `req_ready` both high is appended behind all earlier requests.
- R2: The command output is registered. A slot offered in cycle N produces its command fields in cycle N+1. When nothing is issued, `cmd_valid` is low and `cmd_code` is 0. Codes are NOP=0, PRE=1, ACT=2, RD=3, WR=4, RDA=5 (read with auto-precharge), WRA=6 (write with auto-precharge). After reset no command is valid and the queue is empty.
- R3: With no slot offered, an empty queue, or no queued request for the offered bank, the result is no command.
- R4: When the head request targets the offered bank, its next command is issued. The next command is ACT if the bank is closed, PRE if a different row is open, and the column command if the same row is open.
- R5: Issuing a column command removes the head request. Issuing PRE or ACT leaves the request queued.
- R6: When the head targets another bank, the oldest queued request for the offered bank is chosen. If its next command is PRE or ACT, that command is issued for it.
- R7: If that non-head request's next command would be a column command, no command is issued, so no column access overtakes an earlier request.
- R8: ACT opens the bank at the request's row. PRE closes the bank. RDA and WRA leave the bank closed after the access, so the next request to the same row needs ACT again.
- R9: A push and a head removal in the same cycle are both honoured, and the remaining requests keep their order.
- R10: An issued command carries the bank, row and tag of the request it serves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Queue can accept a request |
| req_bank | input | 2 | Request target bank |
| req_row | input | 14 | Request target row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after the column access |
| req_tag | input | 4 | Request identifier |
| slot_valid | input | 1 | A command slot is offered |
| slot_bank | input | 2 | Bank the slot is offered to |
| cmd_valid | output | 1 | A command was issued |
| cmd_code | output | 3 | Command code (see R2) |
| cmd_bank | output | 2 | Bank of the issued command |
| cmd_row | output | 14 | Row of the served request |
| cmd_tag | output | 4 | Tag of the served request |

## Verification
Every command field is due exactly one cycle after the slot that caused it, because the decision passes through a single output register. Bank state and queue contents change on that same edge, so they affect the answer to the next slot. `req_ready` is due one cycle after the push or removal that changes the fill level. The bench drives inputs on the falling edge and compares against its behavioural model on the next falling edge, which is exactly one rising edge later; all of these results have settled by then.

// File: rtl/ios_pkg.sv
`timescale 1ns/1ps
package ios_pkg;
    localparam int unsigned BANK_W    = 2;
    localparam int unsigned NUM_BANKS = 1 << BANK_W;
    localparam int unsigned ROW_W     = 14;
    localparam int unsigned TAG_W     = 4;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RDA = 3'd5,
        CMD_WRA = 3'd6
    } cmd_e;

    typedef struct packed {
        bank_t bank;
        row_t  row;
        logic  wr;
        logic  ap;
        tag_t  tag;
    } req_t;

    typedef struct packed {
        cmd_e  code;
        bank_t bank;
        row_t  row;
        tag_t  tag;
    } cmd_t;

    function automatic cmd_e col_code(input logic wr, input logic ap);
        case ({wr, ap})
            2'b00:   return CMD_RD;
            2'b01:   return CMD_RDA;
            2'b10:   return CMD_WR;
            default: return CMD_WRA;
        endcase
    endfunction

    function automatic logic is_col(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

    function automatic cmd_e next_cmd(input logic open, input row_t orow, input req_t r);
        if (!open)
            return CMD_ACT;
        else if (orow != r.row)
            return CMD_PRE;
        else
            return col_code(r.wr, r.ap);
    endfunction
endpackage

// File: rtl/ios_queue.sv
`timescale 1ns/1ps
module ios_queue
    import ios_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  req_t             push_ent,
    input  logic             pop,
    output req_t             ent [DEPTH],
    output logic [DEPTH-1:0] vld,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [CNT_W-1:0] wr_idx;

    assign wr_idx = count - CNT_W'(pop);
    assign full   = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count + CNT_W'(push) - CNT_W'(pop);
    end

    // Head sits at slot 0; removal shifts everyone forward by one.
    always_ff @(posedge clk) begin
        if (pop) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++)
                ent[i] <= ent[i+1];
        end
        if (push)
            ent[wr_idx] <= push_ent;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld[g] = (count > CNT_W'(g));
    end
endmodule

// File: rtl/ios_banks.sv
`timescale 1ns/1ps
module ios_banks
    import ios_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  cmd_e                 code,
    input  bank_t                bank,
    input  row_t                 row,
    output logic [NUM_BANKS-1:0] open,
    output row_t                 orow [NUM_BANKS]
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic op_q;
        row_t row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                op_q  <= 1'b0;
                row_q <= '0;
            end else if (upd && bank == bank_t'(g)) begin
                case (code)
                    CMD_ACT: begin
                        op_q  <= 1'b1;
                        row_q <= row;
                    end
                    CMD_PRE, CMD_RDA, CMD_WRA: op_q <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign open[g] = op_q;
        assign orow[g] = row_q;
    end
endmodule

// File: rtl/ios_pick.sv
`timescale 1ns/1ps
module ios_pick
    import ios_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  req_t                 ent [DEPTH],
    input  logic [DEPTH-1:0]     vld,
    input  logic [NUM_BANKS-1:0] open,
    input  row_t                 orow [NUM_BANKS],
    input  logic                 slot_valid,
    input  bank_t                slot_bank,
    output logic                 issue,
    output cmd_t                 dec,
    output logic                 pop
);
    logic [DEPTH-1:0] match;
    logic             sel_found;
    logic [IDX_W-1:0] sel_idx;
    cmd_e             head_cmd;
    cmd_e             oth_cmd;
    req_t             oth;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match[g] = vld[g] && (ent[g].bank == slot_bank);
    end

    // Oldest matching request behind the head.
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int i = 1; i < int'(DEPTH); i++) begin
            if (!sel_found && match[i]) begin
                sel_found = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
    end

    assign oth      = ent[sel_idx];
    assign head_cmd = next_cmd(open[slot_bank], orow[slot_bank], ent[0]);
    assign oth_cmd  = next_cmd(open[slot_bank], orow[slot_bank], oth);

    always_comb begin
        issue = 1'b0;
        pop   = 1'b0;
        dec   = '{code: CMD_NOP, bank: slot_bank, row: '0, tag: '0};
        if (slot_valid && match[0]) begin
            issue = 1'b1;
            pop   = is_col(head_cmd);
            dec   = '{code: head_cmd, bank: slot_bank, row: ent[0].row, tag: ent[0].tag};
        end else if (slot_valid && sel_found && !is_col(oth_cmd)) begin
            issue = 1'b1;
            dec   = '{code: oth_cmd, bank: slot_bank, row: oth.row, tag: oth.tag};
        end
    end
endmodule

// File: rtl/ios_sched.sv
`timescale 1ns/1ps
module ios_sched
    import ios_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              slot_valid,
    input  logic [BANK_W-1:0] slot_bank,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [TAG_W-1:0]  cmd_tag
);
    req_t                 q_ent [DEPTH];
    logic [DEPTH-1:0]     q_vld;
    logic [CNT_W-1:0]     q_count;
    logic                 q_full;
    logic                 q_push;
    logic                 q_pop;
    logic [NUM_BANKS-1:0] b_open;
    row_t                 b_row [NUM_BANKS];
    logic                 issue;
    cmd_t                 dec;
    cmd_t                 cmd_q;
    req_t                 in_req;

    assign req_ready = !q_full;
    assign q_push    = req_valid && req_ready;
    assign in_req    = '{bank: req_bank, row: req_row, wr: req_write, ap: req_autopre, tag: req_tag};

    ios_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_ent (in_req),
        .pop      (q_pop),
        .ent      (q_ent),
        .vld      (q_vld),
        .count    (q_count),
        .full     (q_full)
    );

    ios_banks u_banks (
        .clk  (clk),
        .rst  (rst),
        .upd  (issue),
        .code (dec.code),
        .bank (dec.bank),
        .row  (dec.row),
        .open (b_open),
        .orow (b_row)
    );

    ios_pick #(.DEPTH(DEPTH)) u_pick (
        .ent        (q_ent),
        .vld        (q_vld),
        .open       (b_open),
        .orow       (b_row),
        .slot_valid (slot_valid),
        .slot_bank  (slot_bank),
        .issue      (issue),
        .dec        (dec),
        .pop        (q_pop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_q     <= '{code: CMD_NOP, bank: '0, row: '0, tag: '0};
        end else begin
            cmd_valid <= issue;
            cmd_q     <= issue ? dec : '{code: CMD_NOP, bank: '0, row: '0, tag: '0};
        end
    end

    assign cmd_code = cmd_q.code;
    assign cmd_bank = cmd_q.bank;
    assign cmd_row  = cmd_q.row;
    assign cmd_tag  = cmd_q.tag;
endmodule

// File: rtl/ios_sched_chk.sv
`timescale 1ns/1ps
module ios_sched_chk
    import ios_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              slot_valid,
    input logic [BANK_W-1:0] slot_bank,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic [CNT_W-1:0]  q_count,
    input logic              q_pop
);
    cmd_e                 cc;
    logic [NUM_BANKS-1:0] sh_open;
    row_t                 sh_row [NUM_BANKS];

    assign cc = cmd_e'(cmd_code);

    // Shadow of bank state rebuilt from the emitted command stream.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_open <= '0;
            for (int b = 0; b < int'(NUM_BANKS); b++) sh_row[b] <= '0;
        end else if (cmd_valid) begin
            case (cc)
                CMD_ACT: begin
                    sh_open[cmd_bank] <= 1'b1;
                    sh_row[cmd_bank]  <= cmd_row;
                end
                CMD_PRE, CMD_RDA, CMD_WRA: sh_open[cmd_bank] <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_idle_code_nop_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> cc == CMD_NOP);

    assert_no_slot_no_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |=> !cmd_valid);

    assert_empty_no_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |=> !cmd_valid);

    assert_bank_follows_slot_R10: assert property (@(posedge clk) disable iff (rst)
        slot_valid |=> (!cmd_valid || cmd_bank == $past(slot_bank)));

    assert_push_grows_fill_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !q_pop) |=> q_count == CNT_W'($past(q_count) + 1'b1));

    assert_push_pop_keeps_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && q_pop) |=> q_count == $past(q_count));

    assert_pop_gives_column_R5: assert property (@(posedge clk) disable iff (rst)
        q_pop |=> (cmd_valid && is_col(cc)));

    assert_act_on_closed_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cc == CMD_ACT) |-> !sh_open[cmd_bank]);

    assert_pre_on_other_row_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cc == CMD_PRE) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] != cmd_row));

    assert_column_hits_open_row_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_col(cc)) |-> (sh_open[cmd_bank] && sh_row[cmd_bank] == cmd_row));
endmodule

bind ios_sched ios_sched_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .slot_valid (slot_valid),
    .slot_bank  (slot_bank),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_bank   (cmd_bank),
    .cmd_row    (cmd_row),
    .q_count    (q_count),
    .q_pop      (q_pop)
);

// File: tb/tb_ios_sched.sv
`timescale 1ns/1ps
module tb_ios_sched;
    import ios_pkg::*;

    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic              req_write = 1'b0;
    logic              req_autopre = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              slot_valid = 1'b0;
    logic [BANK_W-1:0] slot_bank = '0;
    logic              cmd_valid;
    logic [2:0]        cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [TAG_W-1:0]  cmd_tag;

    always #2.5 clk = ~clk;

    ios_sched #(.DEPTH(DEPTH)) dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_row (req_row), .req_write (req_write),
        .req_autopre (req_autopre), .req_tag (req_tag),
        .slot_valid (slot_valid), .slot_bank (slot_bank),
        .cmd_valid (cmd_valid), .cmd_code (cmd_code), .cmd_bank (cmd_bank),
        .cmd_row (cmd_row), .cmd_tag (cmd_tag)
    );

    typedef struct {
        int bank;
        int row;
        int wr;
        int ap;
        int tag;
    } mreq_t;

    mreq_t mq[$];
    int    m_open [NUM_BANKS];
    int    m_orow [NUM_BANKS];
    int    m_valid, m_code, m_bank, m_row, m_tag, m_pp;
    string m_rule = "R2";
    int    checks = 0;
    int    fails = 0;
    int    wd = 0;
    int    tagc = 0;

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic int nextc(input mreq_t r);
        if (m_open[r.bank] == 0) return 2;
        if (m_orow[r.bank] != r.row) return 1;
        if (r.wr == 0) return (r.ap != 0) ? 5 : 3;
        return (r.ap != 0) ? 6 : 4;
    endfunction

    // Behavioural reference, advanced once per rising edge.
    task automatic model_step();
        int sz = mq.size();
        bit acc = req_valid && (sz < DEPTH);
        bit popped = 1'b0;
        int idx = -1;
        int c = 0;
        mreq_t nr;
        m_valid = 0; m_code = 0; m_bank = 0; m_row = 0; m_tag = 0;
        m_rule = "R3";
        if (slot_valid && sz > 0) begin
            if (mq[0].bank == int'(slot_bank)) begin
                idx = 0;
                c = nextc(mq[0]);
                m_rule = (c >= 3) ? "R5" : "R4";
            end else begin
                for (int i = 1; i < sz; i++) begin
                    if (idx < 0 && mq[i].bank == int'(slot_bank)) idx = i;
                end
                if (idx > 0) begin
                    c = nextc(mq[idx]);
                    if (c >= 3) begin
                        idx = -1;
                        m_rule = "R7";
                    end else begin
                        m_rule = "R6";
                    end
                end
            end
        end
        if (idx >= 0) begin
            m_valid = 1; m_code = c;
            m_bank = mq[idx].bank; m_row = mq[idx].row; m_tag = mq[idx].tag;
            if (c == 2) begin
                m_open[m_bank] = 1;
                m_orow[m_bank] = m_row;
            end else if (c == 1 || c == 5 || c == 6) begin
                m_open[m_bank] = 0;
            end
            if (c >= 3) begin
                void'(mq.pop_front());
                popped = 1'b1;
            end
        end
        if (acc) begin
            nr.bank = int'(req_bank); nr.row = int'(req_row);
            nr.wr = int'(req_write); nr.ap = int'(req_autopre); nr.tag = int'(req_tag);
            mq.push_back(nr);
        end
        m_pp = int'(acc && popped);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int b = 0; b < NUM_BANKS; b++) begin
                m_open[b] = 0;
                m_orow[b] = 0;
            end
            m_valid = 0; m_code = 0; m_pp = 0; m_rule = "R2";
        end else begin
            model_step();
        end
    end

    // Compare every cycle on the falling edge, one rising edge after stimulus.
    always @(negedge clk) begin
        if (!rst) begin
            chk_eq((m_pp != 0) ? "R9" : "R1", int'(req_ready), int'(mq.size() < DEPTH));
            chk_eq(m_rule, int'(cmd_valid), m_valid);
            chk_eq((m_valid != 0) ? m_rule : "R2", int'(cmd_code), m_code);
            if (m_valid != 0) begin
                chk_eq("R10", int'(cmd_bank), m_bank);
                chk_eq("R10", int'(cmd_row), m_row);
                chk_eq("R10", int'(cmd_tag), m_tag);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            chk_eq("watchdog", 1, 0);
            finish_run();
        end
    end

    task automatic cyc(input bit pv, input int b, input int r, input bit w, input bit ap,
                       input bit sv, input int sb);
        req_valid = pv; req_bank = BANK_W'(b); req_row = ROW_W'(r);
        req_write = w; req_autopre = ap; req_tag = TAG_W'(tagc);
        slot_valid = sv; slot_bank = BANK_W'(sb);
        @(negedge clk);
        tagc++;
        req_valid = 1'b0;
        slot_valid = 1'b0;
    endtask

    task automatic push(input int b, input int r, input bit w, input bit ap);
        cyc(1'b1, b, r, w, ap, 1'b0, 0);
    endtask

    task automatic offer(input int b);
        cyc(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_eq("R2", int'(cmd_valid), 0);
        chk_eq("R2", int'(cmd_code), 0);
        chk_eq("R1", int'(req_ready), 1);

        // Strict column order with early activate behind the head.
        push(0, 5, 1'b0, 1'b0);
        push(1, 7, 1'b1, 1'b0);
        offer(1); chk_eq("R6", int'(cmd_code), 2);
        offer(1); chk_eq("R7", int'(cmd_valid), 0);
        offer(0); chk_eq("R4", int'(cmd_code), 2);
        offer(0); chk_eq("R5", int'(cmd_code), 3);
        offer(1); chk_eq("R5", int'(cmd_code), 4);
        offer(1); chk_eq("R3", int'(cmd_valid), 0);

        // Auto-precharge closes the row.
        push(2, 3, 1'b0, 1'b1);
        push(2, 3, 1'b0, 1'b0);
        offer(2); chk_eq("R4", int'(cmd_code), 2);
        offer(2); chk_eq("R8", int'(cmd_code), 5);
        offer(2); chk_eq("R8", int'(cmd_code), 2);
        offer(2); chk_eq("R5", int'(cmd_code), 3);

        // Row conflict.
        push(2, 9, 1'b1, 1'b0);
        offer(2); chk_eq("R4", int'(cmd_code), 1);
        offer(2); chk_eq("R4", int'(cmd_code), 2);
        offer(2); chk_eq("R4", int'(cmd_code), 4);

        // Push and head removal together.
        push(3, 1, 1'b0, 1'b0);
        offer(3);
        push(0, 6, 1'b0, 1'b0);
        cyc(1'b1, 1, 2, 1'b0, 1'b0, 1'b1, 3);
        chk_eq("R9", int'(cmd_code), 3);
        chk_eq("R9", int'(req_ready), 1);
        offer(1); chk_eq("R6", int'(cmd_code), 1);
        offer(0); chk_eq("R9", int'(cmd_code), 1);
        offer(0); offer(0); chk_eq("R5", int'(cmd_code), 3);
        offer(1); offer(1); chk_eq("R5", int'(cmd_code), 3);

        // Fill to capacity.
        for (int i = 0; i < DEPTH; i++) push(i % 2, 4, 1'b0, 1'b0);
        chk_eq("R1", int'(req_ready), 0);
        push(3, 4, 1'b0, 1'b0);
        chk_eq("R1", int'(req_ready), 0);
        offer(2); chk_eq("R3", int'(cmd_valid), 0);

        // Mixed traffic.
        for (int n = 0; n < 4000; n++) begin
            cyc(($urandom % 2) == 0, int'($urandom % NUM_BANKS), int'($urandom % 3),
                ($urandom % 2) == 0, ($urandom % 4) == 0,
                ($urandom % 4) != 0, int'($urandom % NUM_BANKS));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule